// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block funnels interrupt events from two lower-level groups and a set of direct sources into one active-high, level-sensitive interrupt pin. Each group keeps its own status and enable registers and reduces them to a single summary bit. The first group's summary is also gated by a master enable. Both summaries, together with the direct sources, land in a top-level status register, which has a companion enable register. The enabled top-level bits are ORed, and the result drives the pin through a hold stage.

The hold stage follows its input while a pin-enable configuration bit is 1. While that bit is 0, the pin is frozen at its last value, whatever software writes to the interrupt registers. This lets software deassert a stuck pin, or mask the pin without losing status. All status registers are write-one-to-clear. Software reaches every register over a simple 32-bit word bus with a write strobe and a read strobe.

Top module: `intagg_top`

## Requirements
- R1: After reset every register reads 0 and the interrupt pin is 0.
- R2: An event input sets its bit in the matching status register at the next clock edge. Writing 1 to a status bit clears it. An event that arrives in the same cycle as a clear of its own bit wins, so the bit stays set.
- R3: The first-group summary (top status bit 8) sets only when the OR of (group-A status AND group-A enable bits 5:0) is 1 and the master enable (bit 31 of the group-A enable register) is 1.
- R4: The second-group summary (top status bit 9) sets whenever the OR of (group-B status AND group-B enable bits 10:0) is 1, with no master enable.
- R5: A write that clears a summary bit has no lasting effect while its group still has an enabled pending bit (and, for group A, its master enable is set). The summary clears once the group status is cleared.
- R6: The direct events occupy top status bits 7:0. While pin-enable is 1, the pin equals the OR of (top status AND top enable bits 9:0).
- R7: While pin-enable (bit 0 of the configuration register) is 0, the pin keeps its last value across events and across writes to any status or enable register.
- R8: Setting pin-enable to 1, clearing all top status bits and then setting pin-enable to 0 leaves the pin at 0.
- R9: Clearing the top enable register while pin-enable is 1 and then dropping pin-enable drives the pin to 0 and keeps the top status bits intact. Restoring the enables and then setting pin-enable brings the pin back.
- R10: The word addresses are: 0 group-A status, 1 group-A enable, 2 group-B status, 3 group-B enable, 4 top status, 5 top enable, 6 configuration. A read returns the current register value one cycle after the read strobe. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Word address of the register |
| busWdata | input | 32 | Write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe |
| busRdata | output | 32 | Read data, valid the cycle after busRd |
| evtGrpA | input | 6 | Group-A event inputs, level high sets the bit |
| evtGrpB | input | 11 | Group-B event inputs |
| evtDirect | input | 8 | Direct top-level event inputs |
| irqPin | output | 1 | Active-high interrupt pin |

## Verification
The assertions assume that event inputs and bus strobes are stable around the sampling edge. They also assume that reset is held for at least one edge, with all event inputs low, so that the first sampled history is the cleared state. The bench changes every input at the falling edge and keeps event pulses one cycle long. It issues reads and writes one at a time, so no strobe overlaps another in a way the decode would not see. The only deliberate overlap is an event and a write-one-to-clear of the same bit in the same cycle, which the bench aligns on purpose to probe the priority rule.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_GA_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_GA_EN    = 3'd1;
  localparam logic [ADDR_W-1:0] A_GB_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_GB_EN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_TOP_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_TOP_EN   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CFG      = 3'd6;

  // one write strobe per register, produced by the decode
  typedef struct packed {
    logic wrGaStat;
    logic wrGaEn;
    logic wrGbStat;
    logic wrGbEn;
    logic wrTopStat;
    logic wrTopEn;
    logic wrCfg;
  } regStb_t;
endpackage

// File: rtl/intagg_ctrl.sv
module intagg_ctrl
  import intagg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GA_W   = 6,
  parameter int GB_W   = 11,
  parameter int TOP_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [GA_W-1:0]   gaStat,
  input  logic [GA_W-1:0]   gaEn,
  input  logic              gaMaster,
  input  logic [GB_W-1:0]   gbStat,
  input  logic [GB_W-1:0]   gbEn,
  input  logic [TOP_W-1:0]  topStat,
  input  logic [TOP_W-1:0]  topEn,
  input  logic              pinEn,
  output regStb_t           stb,
  output logic [DATA_W-1:0] busRdata
);
  logic [DATA_W-1:0] rdNext;

  // write decode into strobes
  always_comb begin
    stb = '0;
    if (busWr) begin
      case (busAddr)
        A_GA_STAT:  stb.wrGaStat  = 1'b1;
        A_GA_EN:    stb.wrGaEn    = 1'b1;
        A_GB_STAT:  stb.wrGbStat  = 1'b1;
        A_GB_EN:    stb.wrGbEn    = 1'b1;
        A_TOP_STAT: stb.wrTopStat = 1'b1;
        A_TOP_EN:   stb.wrTopEn   = 1'b1;
        A_CFG:      stb.wrCfg     = 1'b1;
        default:    stb = '0;
      endcase
    end
  end

  // read select, zero-extended
  always_comb begin
    rdNext = '0;
    case (busAddr)
      A_GA_STAT:  rdNext = DATA_W'(gaStat);
      A_GA_EN: begin
        rdNext = DATA_W'(gaEn);
        rdNext[DATA_W-1] = gaMaster;
      end
      A_GB_STAT:  rdNext = DATA_W'(gbStat);
      A_GB_EN:    rdNext = DATA_W'(gbEn);
      A_TOP_STAT: rdNext = DATA_W'(topStat);
      A_TOP_EN:   rdNext = DATA_W'(topEn);
      A_CFG:      rdNext[0] = pinEn;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busRdata <= '0;
    else if (busRd) busRdata <= rdNext;
  end

  // R10: unmapped address reads zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd7) |=> busRdata == '0);
endmodule

// File: rtl/intagg_dp.sv
module intagg_dp
  import intagg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GA_W     = 6,
  parameter int GB_W     = 11,
  parameter int DIRECT_W = 8,
  localparam int TOP_W   = DIRECT_W + 2,
  localparam int SUM_A   = DIRECT_W,
  localparam int SUM_B   = DIRECT_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStb_t             stb,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [GA_W-1:0]     evtGrpA,
  input  logic [GB_W-1:0]     evtGrpB,
  input  logic [DIRECT_W-1:0] evtDirect,
  output logic [GA_W-1:0]     gaStat,
  output logic [GA_W-1:0]     gaEn,
  output logic                gaMaster,
  output logic [GB_W-1:0]     gbStat,
  output logic [GB_W-1:0]     gbEn,
  output logic [TOP_W-1:0]    topStat,
  output logic [TOP_W-1:0]    topEn,
  output logic                pinEn,
  output logic                irqPin
);
  logic [GA_W-1:0]  gaClr;
  logic [GB_W-1:0]  gbClr;
  logic [TOP_W-1:0] topClr;
  logic [TOP_W-1:0] topSet;
  logic             gaPend;
  logic             gbPend;
  logic             anyTop;
  logic             heldQ;
  logic             unusedBits;

  assign unusedBits = ^wdata;

  always_comb begin
    gaClr  = stb.wrGaStat  ? wdata[GA_W-1:0]  : '0;
    gbClr  = stb.wrGbStat  ? wdata[GB_W-1:0]  : '0;
    topClr = stb.wrTopStat ? wdata[TOP_W-1:0] : '0;
    gaPend = (|(gaStat & gaEn)) & gaMaster;
    gbPend = |(gbStat & gbEn);
    topSet = {gbPend, gaPend, evtDirect};
    anyTop = |(topStat & topEn);
    irqPin = pinEn ? anyTop : heldQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gaStat   <= '0;
      gaEn     <= '0;
      gaMaster <= 1'b0;
      gbStat   <= '0;
      gbEn     <= '0;
      topStat  <= '0;
      topEn    <= '0;
      pinEn    <= 1'b0;
      heldQ    <= 1'b0;
    end else begin
      // set after clear: a same-cycle event wins
      gaStat  <= (gaStat & ~gaClr) | evtGrpA;
      gbStat  <= (gbStat & ~gbClr) | evtGrpB;
      topStat <= (topStat & ~topClr) | topSet;
      heldQ   <= irqPin;
      if (stb.wrGaEn) begin
        gaEn     <= wdata[GA_W-1:0];
        gaMaster <= wdata[DATA_W-1];
      end
      if (stb.wrGbEn)  gbEn  <= wdata[GB_W-1:0];
      if (stb.wrTopEn) topEn <= wdata[TOP_W-1:0];
      if (stb.wrCfg)   pinEn <= wdata[0];
    end
  end

  // R2: an event always leaves its bit set
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evtGrpA != '0) |=> ((gaStat & $past(evtGrpA)) == $past(evtGrpA)));

  // R3: group-A summary can only rise with the master enable on
  a_r3_master_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(topStat[SUM_A]) |-> $past(gaMaster));

  // R5: group-B summary falls only on a clear with nothing enabled pending
  a_r5_summary_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(topStat[SUM_B]) |-> ($past(stb.wrTopStat) && ($past(gbStat & gbEn) == '0)));

  // R6: transparent pin is low when no enabled top bit is pending
  a_r6_pin_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (pinEn && ((topStat & topEn) == '0)) |-> !irqPin);

  // R7: frozen pin does not move
  a_r7_pin_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!pinEn && $past(rstN)) |-> $stable(irqPin));
endmodule

// File: rtl/intagg_top.sv
module intagg_top
  import intagg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GA_W     = 6,
  parameter int GB_W     = 11,
  parameter int DIRECT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                busWr,
  input  logic                busRd,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [GA_W-1:0]     evtGrpA,
  input  logic [GB_W-1:0]     evtGrpB,
  input  logic [DIRECT_W-1:0] evtDirect,
  output logic                irqPin
);
  localparam int TOP_W = DIRECT_W + 2;

  regStb_t          stb;
  logic [GA_W-1:0]  gaStat;
  logic [GA_W-1:0]  gaEn;
  logic             gaMaster;
  logic [GB_W-1:0]  gbStat;
  logic [GB_W-1:0]  gbEn;
  logic [TOP_W-1:0] topStat;
  logic [TOP_W-1:0] topEn;
  logic             pinEn;

  intagg_ctrl #(
    .DATA_W(DATA_W), .GA_W(GA_W), .GB_W(GB_W), .TOP_W(TOP_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .gaStat(gaStat), .gaEn(gaEn), .gaMaster(gaMaster),
    .gbStat(gbStat), .gbEn(gbEn), .topStat(topStat), .topEn(topEn),
    .pinEn(pinEn), .stb(stb), .busRdata(busRdata)
  );

  intagg_dp #(
    .DATA_W(DATA_W), .GA_W(GA_W), .GB_W(GB_W), .DIRECT_W(DIRECT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .evtGrpA(evtGrpA), .evtGrpB(evtGrpB), .evtDirect(evtDirect),
    .gaStat(gaStat), .gaEn(gaEn), .gaMaster(gaMaster),
    .gbStat(gbStat), .gbEn(gbEn), .topStat(topStat), .topEn(topEn),
    .pinEn(pinEn), .irqPin(irqPin)
  );
endmodule

// File: tb/test_intagg_top.sv
module test_intagg_top;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic [5:0]  evtGrpA = '0;
  logic [10:0] evtGrpB = '0;
  logic [7:0]  evtDirect = '0;
  logic        irqPin;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  intagg_top i_intagg_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
    .evtGrpA(evtGrpA), .evtGrpB(evtGrpB), .evtDirect(evtDirect),
    .irqPin(irqPin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; d = busRdata;
  endtask

  task automatic readChk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulseA(input logic [5:0] b);
    @(negedge clk); evtGrpA = b; @(negedge clk); evtGrpA = '0;
  endtask
  task automatic pulseB(input logic [10:0] b);
    @(negedge clk); evtGrpB = b; @(negedge clk); evtGrpB = '0;
  endtask
  task automatic pulseD(input logic [7:0] b);
    @(negedge clk); evtDirect = b; @(negedge clk); evtDirect = '0;
  endtask

  task automatic t_reset();
    chk("R1 pin", {31'd0, irqPin}, 32'd0);
    for (int a = 0; a < 8; a++) readChk("R1/R10 reset read", 3'(a), 32'd0);
  endtask

  task automatic t_groupA();
    busWrite(3'd1, 32'h0000_003F);
    pulseA(6'h02);
    readChk("R2 group-A set", 3'd0, 32'h02);
    readChk("R3 master off blocks summary", 3'd4, 32'h000);
    busWrite(3'd1, 32'h8000_003F);
    readChk("R10 group-A enable readback", 3'd1, 32'h8000_003F);
    readChk("R3 summary with master", 3'd4, 32'h100);
    pulseA(6'h08);
    // event on bit 2 together with clear of bits 3 and 2
    @(negedge clk); evtGrpA = 6'h04; busAddr = 3'd0; busWdata = 32'h0C; busWr = 1'b1;
    @(negedge clk); evtGrpA = '0; busWr = 1'b0;
    readChk("R2 event wins over clear", 3'd0, 32'h06);
    busWrite(3'd4, 32'h100);
    readChk("R5 summary stays while pending", 3'd4, 32'h100);
    busWrite(3'd0, 32'h3F);
    readChk("R2 W1C clears group-A", 3'd0, 32'h00);
    busWrite(3'd4, 32'h100);
    readChk("R5 summary clears after group", 3'd4, 32'h000);
    busWrite(3'd1, 32'h0);
  endtask

  task automatic t_groupB();
    busWrite(3'd3, 32'hFFFF_FFFF);
    readChk("R10 group-B enable unused bits zero", 3'd3, 32'h7FF);
    busWrite(3'd3, 32'h400);
    pulseB(11'h001);
    readChk("R4 disabled bit gives no summary", 3'd4, 32'h000);
    pulseB(11'h400);
    readChk("R4 group-B status", 3'd2, 32'h401);
    readChk("R4 summary without master", 3'd4, 32'h200);
    busWrite(3'd2, 32'h7FF);
    busWrite(3'd4, 32'h3FF);
    readChk("R4 cleared", 3'd4, 32'h000);
    busWrite(3'd3, 32'h0);
  endtask

  task automatic t_pin();
    busWrite(3'd6, 32'h1);
    readChk("R10 config readback", 3'd6, 32'h1);
    busWrite(3'd5, 32'h001);
    pulseD(8'h01);
    chk("R6 pin follows enabled direct", {31'd0, irqPin}, 32'd1);
    pulseD(8'h02);
    busWrite(3'd4, 32'h001);
    chk("R6 pin low with only disabled bit", {31'd0, irqPin}, 32'd0);
    readChk("R6 direct bit position", 3'd4, 32'h002);
    busWrite(3'd4, 32'h3FF);
    // freeze high, then disturb the registers
    pulseD(8'h01);
    chk("R6 pin high again", {31'd0, irqPin}, 32'd1);
    busWrite(3'd6, 32'h0);
    busWrite(3'd4, 32'h3FF);
    chk("R7 pin held after status clear", {31'd0, irqPin}, 32'd1);
    busWrite(3'd5, 32'h0);
    chk("R7 pin held after enable clear", {31'd0, irqPin}, 32'd1);
    readChk("R7 status really cleared", 3'd4, 32'h000);
    // stuck-pin release sequence
    busWrite(3'd6, 32'h1);
    busWrite(3'd4, 32'h3FF);
    busWrite(3'd6, 32'h0);
    chk("R8 pin released", {31'd0, irqPin}, 32'd0);
    busWrite(3'd5, 32'h001);
    pulseD(8'h01);
    chk("R7 frozen low ignores event", {31'd0, irqPin}, 32'd0);
  endtask

  task automatic t_mask();
    // state: top status bit 0 set, enable bit 0, pin frozen low
    busWrite(3'd6, 32'h1);
    chk("R9 pin high before mask", {31'd0, irqPin}, 32'd1);
    busWrite(3'd5, 32'h0);
    busWrite(3'd6, 32'h0);
    chk("R9 pin masked", {31'd0, irqPin}, 32'd0);
    readChk("R9 status kept", 3'd4, 32'h001);
    busWrite(3'd5, 32'h001);
    chk("R9 still frozen after enable restore", {31'd0, irqPin}, 32'd0);
    busWrite(3'd6, 32'h1);
    chk("R9 pin back", {31'd0, irqPin}, 32'd1);
  endtask

  initial begin
    #(CLK_P * 50000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_groupA();
    t_groupB();
    t_pin();
    t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule